// File: doc/BRIEF.md
# SPI Page-Buffer Read Responder

This block is an SPI target (mode 0, one active-low chip select) that stands in for the SRAM page buffers of a serial flash device. Its read path serves a family of four buffer-read commands. The host clocks in an opcode byte and then a three-byte address. For the fast variants it also clocks in one dummy byte. The block then streams buffer bytes out on MISO for as long as chip select stays low. The read pointer starts at the address the host supplied, advances one byte at a time, and wraps inside the chosen buffer.

All SPI inputs pass through a small synchronizer into the block's own clock domain. SCLK edges are detected there, so SCLK must run well below the system clock. A host-side write port, separate from SPI, fills the buffers before a test reads them. A parameter selects a device with only one buffer. In that configuration the second-buffer commands count as invalid.

Top module: `spibuf_responder`

## Requirements
- R1: Opcode 0xD1 (no dummy byte) and opcode 0xD4 (one dummy byte) both read buffer 0, which is written with `wr_sel`=0.
- R2: Opcode 0xD3 (no dummy byte) and opcode 0xD6 (one dummy byte) both read buffer 1, which is written with `wr_sel`=1, when `DUAL_BUF`=1.
- R3: For 0xD4 and 0xD6, eight don't-care bits follow the address and MISO stays 0 during them. For 0xD1 and 0xD3, data follows the last address bit directly.
- R4: The address is 24 bits, sent high byte first. Only its low clog2(`BUF_BYTES`) bits are used, and that value is reduced modulo `BUF_BYTES` to give the first byte read.
- R5: Data bytes leave most-significant bit first. MISO changes only after a falling SCLK edge. The first data bit appears after the falling edge that follows the last address bit or dummy bit.
- R6: After each byte the pointer advances. After byte `BUF_BYTES`-1 it returns to byte 0 of the same buffer.
- R7: With `DUAL_BUF`=0, opcodes 0xD3 and 0xD6 are invalid and MISO stays 0 until chip select rises.
- R8: Any other opcode value is ignored: MISO stays 0 and MOSI has no effect until chip select rises.
- R9: While `cs_n` is high, MISO is 0 and all bit and byte counters are cleared. Raising `cs_n` at any bit position ends the transaction, and the next transaction decodes normally.
- R10: A write with `wr_en`=1 stores `wr_data` at `wr_addr` of the buffer picked by `wr_sel`. It is observable through later SPI reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sclk | input | 1 | SPI serial clock (mode 0) |
| cs_n | input | 1 | SPI chip select, active low |
| mosi | input | 1 | SPI data from host |
| miso | output | 1 | SPI data to host |
| wr_en | input | 1 | Preload write strobe |
| wr_sel | input | 1 | Preload buffer select |
| wr_addr | input | clog2(BUF_BYTES) | Preload byte address |
| wr_data | input | 8 | Preload byte value |

## Verification
A falling SCLK edge reaches MISO three system-clock cycles later: two synchronizer stages, then the edge detector and the MISO register. A rise of `cs_n` clears MISO on the same schedule. The bench holds each SCLK level for five clock cycles and samples MISO on the last cycle before it raises SCLK, so every sample lands after the update that is due and before the next one. After each chip-select rise the bench waits eight cycles before it checks that MISO is idle. The bench sweeps all four opcodes over every 4-bit start address of a 12-byte buffer, with reads long enough to wrap. It compares every byte with an arithmetic preload pattern on both a dual-buffer instance and a single-buffer instance.

// File: rtl/spibuf_pkg.sv
package spibuf_pkg;

    localparam logic [7:0] OPC_B0_SLOW = 8'hD1;
    localparam logic [7:0] OPC_B1_SLOW = 8'hD3;
    localparam logic [7:0] OPC_B0_FAST = 8'hD4;
    localparam logic [7:0] OPC_B1_FAST = 8'hD6;

    typedef enum logic [2:0] {
        ST_OPC,
        ST_ADDR,
        ST_DUMMY,
        ST_DATA,
        ST_IGNORE
    } rd_state_e;

    typedef struct packed {
        logic valid;
        logic sel;
        logic fast;
    } op_info_t;

    // Map an opcode onto buffer select and dummy-byte presence.
    function automatic op_info_t decode_op(input logic [7:0] code, input logic dual);
        op_info_t r;
        r = '0;
        case (code)
            OPC_B0_SLOW: r = '{valid: 1'b1, sel: 1'b0, fast: 1'b0};
            OPC_B1_SLOW: r = '{valid: dual, sel: 1'b1, fast: 1'b0};
            OPC_B0_FAST: r = '{valid: 1'b1, sel: 1'b0, fast: 1'b1};
            OPC_B1_FAST: r = '{valid: dual, sel: 1'b1, fast: 1'b1};
            default:     r = '0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/spibuf_sync.sv
module spibuf_sync #(
    parameter int         W       = 3,
    parameter int         STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] st [STAGES];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
        end else begin
            st[0] <= d;
            for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
        end
    end

    assign q = st[STAGES-1];
endmodule

// File: rtl/spibuf_store.sv
module spibuf_store #(
    parameter int BYTES = 264,
    parameter int NBUF  = 2,
    parameter int AW    = $clog2(BYTES)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data,
    input  logic          rd_sel,
    input  logic [AW-1:0] rd_addr,
    output logic [7:0]    rd_data
);
    logic [7:0] rdv [NBUF];

    for (genvar b = 0; b < NBUF; b++) begin : g_buf
        logic [7:0] mem [BYTES];

        always_ff @(posedge clk) begin
            if (wr_en && (int'(wr_sel) == b) && (int'(wr_addr) < BYTES))
                mem[wr_addr] <= wr_data;
        end

        assign rdv[b] = mem[rd_addr];
    end

    assign rd_data = (NBUF > 1 && rd_sel) ? rdv[NBUF-1] : rdv[0];
endmodule

// File: rtl/spibuf_responder.sv
module spibuf_responder
    import spibuf_pkg::*;
#(
    parameter int BUF_BYTES   = 264,
    parameter int DUAL_BUF    = 1,
    parameter int SYNC_STAGES = 2,
    localparam int AW         = $clog2(BUF_BYTES)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          sclk,
    input  logic          cs_n,
    input  logic          mosi,
    output logic          miso,
    input  logic          wr_en,
    input  logic          wr_sel,
    input  logic [AW-1:0] wr_addr,
    input  logic [7:0]    wr_data
);
    localparam int NBUF = (DUAL_BUF != 0) ? 2 : 1;
    localparam logic [AW-1:0] LAST = AW'(BUF_BYTES - 1);

    logic [2:0] sy;
    logic cs_q, sclk_q, mosi_q, sclk_d;
    logic sclk_rise, sclk_fall;

    spibuf_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   ({cs_n, sclk, mosi}),
        .q   (sy)
    );

    assign cs_q   = sy[2];
    assign sclk_q = sy[1];
    assign mosi_q = sy[0];

    always_ff @(posedge clk) begin
        if (rst) sclk_d <= 1'b0;
        else     sclk_d <= sclk_q;
    end

    assign sclk_rise = sclk_q & ~sclk_d;
    assign sclk_fall = ~sclk_q & sclk_d;

    rd_state_e     state;
    logic [2:0]    bit_cnt, out_cnt;
    logic [1:0]    byte_cnt;
    logic [6:0]    in_sh, out_sh;
    logic [AW-1:0] addr_sh, ptr, start;
    logic          sel, fast;
    logic [7:0]    in_byte, rd_data;
    op_info_t      op;

    assign in_byte = {in_sh, mosi_q};
    assign op      = decode_op(in_byte, DUAL_BUF != 0);
    assign start   = AW'(32'({addr_sh[AW-2:0], mosi_q}) % BUF_BYTES);

    spibuf_store #(.BYTES(BUF_BYTES), .NBUF(NBUF), .AW(AW)) u_store (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_sel  (sel),
        .rd_addr (ptr),
        .rd_data (rd_data)
    );

    always_ff @(posedge clk) begin
        if (rst || cs_q) begin
            state    <= ST_OPC;
            bit_cnt  <= '0;
            out_cnt  <= '0;
            byte_cnt <= '0;
            in_sh    <= '0;
            out_sh   <= '0;
            addr_sh  <= '0;
            ptr      <= '0;
            sel      <= 1'b0;
            fast     <= 1'b0;
            miso     <= 1'b0;
        end else begin
            if (sclk_rise) begin
                in_sh   <= in_byte[6:0];
                bit_cnt <= bit_cnt + 3'd1;
                if (state == ST_ADDR) addr_sh <= {addr_sh[AW-2:0], mosi_q};
                if (bit_cnt == 3'd7) begin
                    case (state)
                        ST_OPC: begin
                            if (op.valid) begin
                                state <= ST_ADDR;
                                sel   <= op.sel;
                                fast  <= op.fast;
                            end else begin
                                state <= ST_IGNORE;
                            end
                        end
                        ST_ADDR: begin
                            byte_cnt <= byte_cnt + 2'd1;
                            if (byte_cnt == 2'd2) begin
                                ptr   <= start;
                                state <= fast ? ST_DUMMY : ST_DATA;
                            end
                        end
                        ST_DUMMY: state <= ST_DATA;
                        default: ;
                    endcase
                end
            end
            if (sclk_fall && state == ST_DATA) begin
                if (out_cnt == 3'd0) begin
                    miso   <= rd_data[7];
                    out_sh <= rd_data[6:0];
                    ptr    <= (ptr == LAST) ? '0 : ptr + AW'(1);
                end else begin
                    miso   <= out_sh[6];
                    out_sh <= {out_sh[5:0], 1'b0};
                end
                out_cnt <= out_cnt + 3'd1;
            end
        end
    end
endmodule

// File: rtl/spibuf_responder_chk.sv
module spibuf_responder_chk
    import spibuf_pkg::*;
#(
    parameter int BUF_BYTES = 264,
    parameter int DUAL_BUF  = 1,
    parameter int AW        = $clog2(BUF_BYTES)
) (
    input logic          clk,
    input logic          rst,
    input logic          cs_q,
    input logic          sclk_fall,
    input rd_state_e     state,
    input logic          sel,
    input logic [AW-1:0] ptr,
    input logic          miso
);
    // R9: a synchronized chip-select high forces MISO low on the next cycle
    p_idle_low_r9: assert property (@(posedge clk) disable iff (rst)
        cs_q |=> !miso);

    // R5: MISO moves only after a falling SCLK edge or a chip-select reset
    p_miso_on_fall_r5: assert property (@(posedge clk) disable iff (rst)
        (!sclk_fall && !cs_q) |=> $stable(miso));

    // R3: dummy phase keeps MISO quiet
    p_dummy_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        (state == ST_DUMMY) |-> !miso);

    // R8: ignored transaction keeps MISO quiet
    p_ignore_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IGNORE) |-> !miso);

    // R6: read pointer stays inside the buffer
    p_ptr_range_r6: assert property (@(posedge clk) disable iff (rst)
        int'(ptr) < BUF_BYTES);

    // R7: a single-buffer device never reads the second buffer
    p_single_sel_r7: assert property (@(posedge clk) disable iff (rst)
        (DUAL_BUF == 0 && state == ST_DATA) |-> !sel);
endmodule

bind spibuf_responder spibuf_responder_chk #(
    .BUF_BYTES (BUF_BYTES),
    .DUAL_BUF  (DUAL_BUF)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cs_q      (cs_q),
    .sclk_fall (sclk_fall),
    .state     (state),
    .sel       (sel),
    .ptr       (ptr),
    .miso      (miso)
);

// File: tb/sim_spibuf_responder.sv
`timescale 1ns/1ps
module sim_spibuf_responder;
    localparam int BYTES = 12;
    localparam int AW    = $clog2(BYTES);
    localparam int HALF  = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sclk = 1'b0, cs_n = 1'b1, mosi = 1'b0;
    logic miso0, miso1;
    logic wr_en = 1'b0, wr_sel = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    int errors = 0, checks = 0;
    bit done = 0;

    always #4 clk = ~clk;

    spibuf_responder #(.BUF_BYTES(BYTES), .DUAL_BUF(1)) u0 (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso0),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data));

    spibuf_responder #(.BUF_BYTES(BYTES), .DUAL_BUF(0)) u1 (
        .clk(clk), .rst(rst), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso1),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr), .wr_data(wr_data));

    function automatic logic [7:0] pat(input int b, input int a);
        return 8'(((b * 7 + a * 29 + 3) & 255) | 1);
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic spi_bit(input logic tx, output logic r0, output logic r1);
        mosi = tx;
        wait_clk(HALF);
        r0 = miso0;
        r1 = miso1;
        sclk = 1'b1;
        wait_clk(HALF);
        sclk = 1'b0;
    endtask

    task automatic spi_byte(input logic [7:0] tx, output logic [7:0] r0, output logic [7:0] r1);
        for (int i = 7; i >= 0; i--) spi_bit(tx[i], r0[i], r1[i]);
    endtask

    task automatic cs_high(input string req);
        cs_n = 1'b1;
        wait_clk(8);
        chk(miso0 == 1'b0, req, miso0, 0);
        chk(miso1 == 1'b0, req, miso1, 0);
    endtask

    task automatic read_seq(input logic [7:0] opc, input logic [23:0] addr, input int n);
        logic [7:0] r0, r1;
        int b, s;
        bit fast;
        b    = (opc == 8'hD3 || opc == 8'hD6) ? 1 : 0;
        fast = (opc == 8'hD4 || opc == 8'hD6);
        s    = int'(addr[AW-1:0]) % BYTES;
        cs_n = 1'b0;
        wait_clk(4);
        spi_byte(opc, r0, r1);
        spi_byte(addr[23:16], r0, r1);
        spi_byte(addr[15:8], r0, r1);
        spi_byte(addr[7:0], r0, r1);
        if (fast) begin
            spi_byte(8'h00, r0, r1);
        end
        for (int k = 0; k < n; k++) begin
            spi_byte(8'hA5, r0, r1);
            // R1 R2 R4 R5 R6: dual-buffer instance
            chk(r0 == pat(b, (s + k) % BYTES), b ? "R2 R4 R5 R6 dual" : "R1 R4 R5 R6 dual",
                r0, pat(b, (s + k) % BYTES));
            // R7: single-buffer instance answers buffer 1 commands with zeros
            if (b == 1) chk(r1 == 8'h00, "R7 single-buffer", r1, 0);
            else        chk(r1 == pat(0, (s + k) % BYTES), "R1 R10 single", r1, pat(0, (s + k) % BYTES));
        end
        cs_high("R9 idle");
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [7:0] r0, r1;
        logic b0, b1;
        logic [7:0] opcs [4];
        opcs[0] = 8'hD1; opcs[1] = 8'hD3; opcs[2] = 8'hD4; opcs[3] = 8'hD6;
        wait_clk(6);
        rst = 1'b0;
        wait_clk(2);
        chk(miso0 == 1'b0, "R9 reset", miso0, 0);
        chk(miso1 == 1'b0, "R9 reset", miso1, 0);

        // R10: preload both buffers
        for (int b = 0; b < 2; b++) begin
            for (int a = 0; a < BYTES; a++) begin
                wr_en = 1'b1; wr_sel = b[0]; wr_addr = AW'(a); wr_data = pat(b, a);
                wait_clk(1);
            end
        end
        wr_en = 1'b0;
        wait_clk(2);

        // R1 R2 R3 R4 R6: every opcode, every low address value, reads that wrap
        for (int o = 0; o < 4; o++) begin
            for (int a = 0; a < 16; a++) begin
                read_seq(opcs[o], {8'(8'h5A ^ a), 8'hC3, 4'h9, 4'(a)}, BYTES + 1);
            end
        end

        // R8: unknown opcode, MISO quiet for whole transaction
        cs_n = 1'b0;
        wait_clk(4);
        spi_byte(8'h52, r0, r1);
        for (int k = 0; k < 5; k++) begin
            spi_byte(8'hD4, r0, r1);
            chk(r0 == 8'h00, "R8 ignored opcode", r0, 0);
            chk(r1 == 8'h00, "R8 ignored opcode", r1, 0);
        end
        cs_high("R8 R9 idle");

        // R9: abort in the middle of a data byte, then a fresh read
        cs_n = 1'b0;
        wait_clk(4);
        spi_byte(8'hD4, r0, r1);
        spi_byte(8'h00, r0, r1);
        spi_byte(8'h00, r0, r1);
        spi_byte(8'h05, r0, r1);
        spi_byte(8'h00, r0, r1);
        spi_byte(8'h00, r0, r1);
        chk(r0 == pat(0, 5), "R3 R9 pre-abort", r0, pat(0, 5));
        for (int i = 0; i < 5; i++) spi_bit(1'b1, b0, b1);
        cs_high("R9 abort data");
        read_seq(8'hD1, 24'h000009, 3);

        // R9: abort in the middle of the address
        cs_n = 1'b0;
        wait_clk(4);
        spi_byte(8'hD3, r0, r1);
        spi_byte(8'hFF, r0, r1);
        for (int i = 0; i < 3; i++) spi_bit(1'b1, b0, b1);
        cs_high("R9 abort address");
        read_seq(8'hD6, 24'h000002, 2);

        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule